// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block collects a set of level-sensitive interrupt request lines from peripherals and combines them into a single interrupt request to a processor. A request counts only while its mask bit is clear. Whenever at least one unmasked line is active, the controller raises its interrupt output. It also presents a vector equal to a build-time base value plus the index of the winning line. When several lines are active together, a priority order fixed at build time picks the winner.

The processor answers with an acknowledge level. On the edge where the acknowledge is sampled, the controller freezes the winning vector, lowers the interrupt output and raises an in-service indicator. It stays in service until the acknowledge is released.

Several devices may drive one request line through an external OR. The line then stays active until every device on it has been serviced, so the controller raises its interrupt again after each service while any of those devices still requests.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `in_service_o` is 0 and `vector_o` is 0.
- R2: A request line counts as pending when its `line_req_i` bit is 1 and its `line_mask_i` bit is 0. When any line is pending while the controller is idle, `irq_o` is 1 after the next rising clock edge.
- R3: `irq_o` stays 1 while `ack_i` is 0 and a line is pending. The first edge that samples `ack_i` = 1 with a line pending lowers `irq_o` and raises `in_service_o`.
- R4: With the default `LOW_FIRST` = 1, the pending line with the lowest index wins. With `LOW_FIRST` = 0, the highest index wins.
- R5: While `irq_o` is 1, `vector_o` equals `VEC_BASE` plus the index of the current winner, sampled at the previous edge. It follows a new winner when a line of higher priority becomes pending.
- R6: A line whose mask bit is 1 never raises `irq_o` and never selects the vector.
- R7: The vector is captured on the edge that samples the acknowledge. It stays unchanged for the whole service, even when new requests arrive.
- R8: `in_service_o` falls on the edge that samples `ack_i` = 0. If a line is still pending, `irq_o` returns to 1 on the following edge.
- R9: If every pending line is withdrawn before the acknowledge, `irq_o` falls on the next edge and no service starts.
- R10: `ack_i` sampled while the controller is idle and no line is pending has no effect: `irq_o` and `in_service_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_req_i | input | N_LINES | Level request per interrupt line |
| line_mask_i | input | N_LINES | Per-line block bit, 1 = ignored |
| ack_i | input | 1 | Processor acknowledge level |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | VEC_W | `VEC_BASE` + winning line index |
| in_service_o | output | 1 | High while an acknowledged interrupt is being serviced |

## Verification
The assertions assume the processor raises `ack_i` only while `irq_o` is high, or while nothing is pending. They also assume it releases `ack_i` once service is finished, because a held acknowledge keeps the controller in service. The stimulus changes requests, masks and the acknowledge only at falling clock edges, so no change is sampled at the edge where it is driven. It drops the acknowledge at the end of every service. New requests injected during service test the frozen vector without breaking the handshake order.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RAISE = 2'd1,
      ST_SERVE = 2'd2
   } irq_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
   parameter int N_LINES = 8
) (
   input  logic [N_LINES-1:0] req_i,
   input  logic [N_LINES-1:0] mask_i,
   output logic [N_LINES-1:0] pend_o,
   output logic               any_o
);

   genvar gi;
   generate
      for (gi = 0; gi < N_LINES; gi++) begin : g_line
         assign pend_o[gi] = req_i[gi] & ~mask_i[gi];
      end
   endgenerate

   assign any_o = |pend_o;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N_LINES   = 8,
   parameter int IDX_W     = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N_LINES-1:0] pend_i,
   output logic [N_LINES-1:0] grant_o,
   output logic [IDX_W-1:0]   idx_o
);

   genvar gi;
   generate
      if (LOW_FIRST) begin : g_low
         logic [N_LINES:0] blk;
         assign blk[0] = 1'b0;
         for (gi = 0; gi < N_LINES; gi++) begin : g_chain
            assign blk[gi+1]   = blk[gi] | pend_i[gi];
            assign grant_o[gi] = pend_i[gi] & ~blk[gi];
         end
      end else begin : g_high
         logic [N_LINES:0] blk;
         assign blk[N_LINES] = 1'b0;
         for (gi = 0; gi < N_LINES; gi++) begin : g_chain
            assign blk[gi]     = blk[gi+1] | pend_i[gi];
            assign grant_o[gi] = pend_i[gi] & ~blk[gi+1];
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N_LINES; i++) begin
         if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
      end
   end

   // R4: at most one line wins
   always_comb begin
      if (!$isunknown(pend_i)) begin
         assert_onehot_grant_R4: assert ($onehot0(grant_o))
            else $error("grant not one-hot");
      end
   end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
   import irq_prio_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_i,
   input  logic [IDX_W-1:0] win_i,
   input  logic             ack_i,
   output logic             int_o,
   output logic             svc_o,
   output logic [VEC_W-1:0] vec_o
);

   irq_state_e st_q;
   logic [VEC_W-1:0] vec_q;
   logic [VEC_W-1:0] vec_next;

   assign vec_next = VEC_W'(VEC_BASE) + VEC_W'(win_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         vec_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (any_i) begin
                  st_q  <= ST_RAISE;
                  vec_q <= vec_next;
               end
            end
            ST_RAISE: begin
               if (!any_i) begin
                  st_q <= ST_IDLE;
               end else begin
                  vec_q <= vec_next;
                  if (ack_i) st_q <= ST_SERVE;
               end
            end
            ST_SERVE: begin
               if (!ack_i) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign int_o = (st_q == ST_RAISE);
   assign svc_o = (st_q == ST_SERVE);
   assign vec_o = vec_q;

   assert_ack_drops_int_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_o && ack_i |=> !int_o)
      else $error("irq not lowered after acknowledge");

   assert_int_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_o && !ack_i && any_i |=> int_o)
      else $error("irq dropped before acknowledge");

   assert_no_spurious_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !int_o && !svc_o && !any_i |=> !int_o)
      else $error("irq raised with nothing pending");

   assert_vec_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      svc_o && ack_i |=> $stable(vec_o))
      else $error("vector moved during service");

   assert_svc_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_o && svc_o))
      else $error("irq and service high together");

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int N_LINES   = 8,
   parameter int VEC_W     = 8,
   parameter int VEC_BASE  = 64,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] line_req_i,
   input  logic [N_LINES-1:0] line_mask_i,
   input  logic               ack_i,
   output logic               irq_o,
   output logic [VEC_W-1:0]   vector_o,
   output logic               in_service_o
);

   localparam int IDX_W = irq_prio_pkg::idx_width(N_LINES);

   generate
      if (N_LINES < 1) begin : g_bad_lines
         $error("N_LINES must be at least 1");
      end
      if (VEC_BASE < 0 || (VEC_BASE + N_LINES) > (2 ** VEC_W)) begin : g_bad_vec
         $error("VEC_BASE + N_LINES does not fit in VEC_W bits");
      end
   endgenerate

   logic [N_LINES-1:0] pend;
   logic [N_LINES-1:0] grant;
   logic               any_pend;
   logic [IDX_W-1:0]   win_idx;

   irq_req_gate #(.N_LINES(N_LINES)) gate_i (
      .req_i  (line_req_i),
      .mask_i (line_mask_i),
      .pend_o (pend),
      .any_o  (any_pend)
   );

   irq_prio_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W), .LOW_FIRST(LOW_FIRST)) pick_i (
      .pend_i  (pend),
      .grant_o (grant),
      .idx_o   (win_idx)
   );

   irq_ack_fsm #(.IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) fsm_i (
      .clk   (clk),
      .rst_n (rst_n),
      .any_i (any_pend),
      .win_i (win_idx),
      .ack_i (ack_i),
      .int_o (irq_o),
      .svc_o (in_service_o),
      .vec_o (vector_o)
   );

   // R6: a masked line must never hold the grant
   always_comb begin
      if (!$isunknown({line_mask_i, line_req_i})) begin
         assert_mask_no_grant_R6: assert ((grant & line_mask_i) == '0)
            else $error("masked line granted");
      end
   end

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

   localparam int N    = 8;
   localparam int BASE = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] mask = '0;
   logic         ack = 1'b0;
   logic         irq;
   logic [7:0]   vec;
   logic         svc;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_prio_ctrl #(.N_LINES(N), .VEC_W(8), .VEC_BASE(BASE), .LOW_FIRST(1'b1)) dut_i (
      .clk (clk), .rst_n (rst_n), .line_req_i (req), .line_mask_i (mask),
      .ack_i (ack), .irq_o (irq), .vector_o (vec), .in_service_o (svc)
   );

   // {req, mask, expect_irq, expect_idx}
   localparam logic [19:0] TBL [8] = '{
      {8'h01, 8'h00, 1'b1, 3'd0},
      {8'h80, 8'h00, 1'b1, 3'd7},
      {8'hA4, 8'h00, 1'b1, 3'd2},
      {8'hA4, 8'h04, 1'b1, 3'd5},
      {8'hFF, 8'h0F, 1'b1, 3'd4},
      {8'h30, 8'h30, 1'b0, 3'd0},
      {8'h18, 8'h00, 1'b1, 3'd3},
      {8'hC0, 8'h40, 1'b1, 3'd7}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk("R1 irq after reset", irq, 0);
      chk("R1 in_service after reset", svc, 0);
      chk("R1 vector after reset", vec, 0);
      rst_n = 1'b1;
      step();

      for (int e = 0; e < 8; e++) begin
         req  = TBL[e][19:12];
         mask = TBL[e][11:4];
         step();
         if (TBL[e][3]) begin
            chk("R2 irq raised", irq, 1);
            chk("R4/R5 vector", vec, BASE + TBL[e][2:0]);
            ack = 1'b1;
            step();
            chk("R3 irq dropped on ack", irq, 0);
            chk("R3 in_service on ack", svc, 1);
            chk("R7 vector at ack", vec, BASE + TBL[e][2:0]);
            held = vec;
            req  = 8'hFF;
            mask = 8'h00;
            step();
            chk("R7 vector frozen on late request", vec, held);
            req = '0;
            ack = 1'b0;
            step();
            chk("R8 in_service released", svc, 0);
            step();
            chk("R8 idle with no request", irq, 0);
         end else begin
            chk("R6 masked request ignored", irq, 0);
            step();
            chk("R6 masked request still ignored", irq, 0);
            chk("R6 no service", svc, 0);
         end
         req  = '0;
         mask = '0;
         step();
      end

      // R3: irq held over several cycles without ack
      req = 8'h08;
      step();
      repeat (4) step();
      chk("R3 irq held without ack", irq, 1);
      // R5: higher priority line arrives before ack
      req = 8'h0C;
      step();
      chk("R5 vector follows new winner", vec, BASE + 2);
      // R8: keep request during service, then re-raise
      ack = 1'b1;
      step();
      chk("R8 in service", svc, 1);
      ack = 1'b0;
      step();
      chk("R8 in_service falls", svc, 0);
      chk("R8 irq low during gap", irq, 0);
      step();
      chk("R8 irq re-raised for held level", irq, 1);
      // R9: withdraw before ack
      req = '0;
      step();
      chk("R9 irq drops on withdraw", irq, 0);
      chk("R9 no service on withdraw", svc, 0);
      // R10: ack while idle
      ack = 1'b1;
      step();
      step();
      chk("R10 ack idle irq", irq, 0);
      chk("R10 ack idle in_service", svc, 0);
      ack = 1'b0;
      step();
      // R6: mask applied while raised drops the request
      req = 8'h02;
      step();
      chk("R2 irq for line 1", irq, 1);
      mask = 8'h02;
      step();
      chk("R6 mask withdraws irq", irq, 0);
      req  = '0;
      mask = '0;
      step();

      finish_run();
   end

endmodule